// File: doc/BRIEF.md
# Configuration Space Access Bridge

This block gives a host processor indirect access to device configuration registers through two ports. The first port is a 32-bit selector register. It holds an enable flag, a bus number, a combined device/function number and a register offset. The second port is a 4-byte data window. Each access to the window becomes at most one configuration read or write toward the device named by the selector.

Before it issues anything on the target side, the bridge checks a set of conditions: the enable flag, device presence, device power, a hot-added function whose function 0 is missing, and the end of configuration space. If any check fails, a read returns all ones and a write disappears with no target request. Accesses that pass are clipped at the end of configuration space. The bridge turns them into byte enables and places the data in the correct lane. Read data comes back right-aligned and registered one cycle after the host access.

Top module: `cfgh_top`

## Requirements
- R1: A write to the selector port takes effect only when the host offset is 0 and the length is 4 bytes. Any other selector write leaves the stored value unchanged.
- R2: A selector-port read returns the full stored 32-bit value for any offset and length.
- R3: The selector resets to zero. While selector bit 31 is 0, data-window reads return 0xFFFFFFFF and data-window writes raise no target request.
- R4: The target bus number is selector bits 23:16. The device/function number is selector bits 15:8.
- R5: The register offset is {selector[7:2], selector[1:0] OR host offset}, and its low two bits select the byte lane.
- R6: When `tgt_present_i` is low, a data read returns all ones and a data write raises no request.
- R7: A read returns all ones and a write raises no request in either of two cases: `tgt_powered_i` is low, or `tgt_hotadd_i` is high while `tgt_fn0_present_i` is low.
- R8: When the register offset is CFG_LIMIT or more (default 256), the access fails as in R6. Otherwise the byte count is the smaller of the host length and CFG_LIMIT minus the offset.
- R9: Byte enable bit i is set when lane ≤ i < lane + count, for i in 0..3. Write data is shifted left by 8×lane bits.
- R10: Read data is the target word shifted right by 8×lane bits. Only the low N bytes are kept, where N is the number of set byte enables; all higher bytes are zero.
- R11: Every host read gives `host_rvalid_o` high on the next cycle, with data in `host_rdata_o`. A passing data-window access raises `tgt_req_o` for exactly the cycle of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_data_i | input | 1 | 1 = data window, 0 = selector port |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_off_i | input | 2 | Byte offset inside the port |
| host_len_i | input | 3 | Access length in bytes: 1, 2 or 4 |
| host_wdata_i | input | 32 | Right-aligned write data |
| host_rdata_o | output | 32 | Read result, registered |
| host_rvalid_o | output | 1 | Read result valid |
| tgt_req_o | output | 1 | Configuration request strobe |
| tgt_we_o | output | 1 | Request direction, 1 = write |
| tgt_bus_o | output | 8 | Target bus number |
| tgt_devfn_o | output | 8 | Target device/function number |
| tgt_off_o | output | 8 | Register byte offset |
| tgt_be_o | output | 4 | Byte enables |
| tgt_wdata_o | output | 32 | Lane-aligned write data |
| tgt_present_i | input | 1 | A device answers at the decoded bus/devfn |
| tgt_powered_i | input | 1 | The addressed device has power |
| tgt_hotadd_i | input | 1 | The addressed function was hot-added |
| tgt_fn0_present_i | input | 1 | Function 0 of the addressed device exists |
| tgt_rdata_i | input | 32 | Target read word, same cycle as request |

## Verification
A corrupted selector shows up on the very next data access. It appears as a wrong bus, devfn or offset, or as a request where none should exist, and the next selector read returns the wrong value. A fault in the gating or clipping logic shows up on the target lines in the same cycle as the access. It takes one of three forms: a request that should not be there, a missing request, or a wrong byte-enable pattern. Read data from an access that should have failed is not all ones. Alignment faults appear one cycle later in `host_rdata_o`, as shifted or unmasked bytes.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LANES      = WORD_W / 8;
  localparam int unsigned REG_OFF_W  = 8;
  localparam int unsigned BUS_W      = 8;
  localparam int unsigned DEVFN_W    = 8;
  localparam int unsigned ENABLE_BIT = 31;
  localparam int unsigned BUS_LSB    = 16;
  localparam int unsigned DEVFN_LSB  = 8;
  localparam logic [2:0]  LEN_WORD   = 3'd4;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cfgh_addr_reg.sv
module cfgh_addr_reg
  import cfgh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] off_i,
  input  logic [2:0] len_i,
  input  word_t      wdata_i,
  output word_t      addr_q_o
);
  logic accept;

  // only aligned full-word writes land
  assign accept = wr_i && (off_i == 2'd0) && (len_i == LEN_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q_o <= '0;
    else if (accept) addr_q_o <= wdata_i;
  end
endmodule

// File: rtl/cfgh_decode.sv
module cfgh_decode
  import cfgh_pkg::*;
#(
  parameter int unsigned CFG_LIMIT = 256
) (
  input  logic [REG_OFF_W-1:0] addr_lo_i,
  input  logic [1:0]           off_i,
  input  logic [2:0]           len_i,
  output logic [REG_OFF_W-1:0] reg_off_o,
  output logic [1:0]           lane_o,
  output logic [LANES-1:0]     be_o,
  output logic                 in_range_o
);
  int unsigned rem;
  logic [2:0]  nbytes;
  logic [2:0]  lane_ext;

  always_comb begin
    reg_off_o  = {addr_lo_i[REG_OFF_W-1:2], addr_lo_i[1:0] | off_i};
    in_range_o = 32'(reg_off_o) < CFG_LIMIT;
    rem        = in_range_o ? (CFG_LIMIT - 32'(reg_off_o)) : 32'd0;
    nbytes     = (32'(len_i) <= rem) ? len_i : 3'(rem);
  end

  assign lane_o   = reg_off_o[1:0];
  assign lane_ext = {1'b0, lane_o};

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign be_o[i] = (3'(i) >= lane_ext) && (3'(i) < (lane_ext + nbytes));
  end
endmodule

// File: rtl/cfgh_resp.sv
module cfgh_resp
  import cfgh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             sel_data_i,
  input  logic             pass_i,
  input  word_t            addr_q_i,
  input  logic [1:0]       lane_i,
  input  logic [LANES-1:0] be_i,
  input  word_t            tgt_rdata_i,
  output word_t            rdata_o,
  output logic             rvalid_o
);
  word_t      shifted;
  word_t      aligned;
  word_t      nxt;
  logic [2:0] nkeep;

  assign shifted = tgt_rdata_i >> {lane_i, 3'b000};
  assign nkeep   = 3'($countones(be_i));

  for (genvar k = 0; k < LANES; k++) begin : g_keep
    assign aligned[8*k +: 8] = (3'(k) < nkeep) ? shifted[8*k +: 8] : 8'h00;
  end

  always_comb begin
    if (!sel_data_i)  nxt = addr_q_i;
    else if (pass_i)  nxt = aligned;
    else              nxt = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= nxt;
    end
  end
endmodule

// File: rtl/cfgh_top.sv
module cfgh_top
  import cfgh_pkg::*;
#(
  parameter int unsigned CFG_LIMIT = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_req_i,
  input  logic        host_data_i,
  input  logic        host_we_i,
  input  logic [1:0]  host_off_i,
  input  logic [2:0]  host_len_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o,
  output logic        host_rvalid_o,
  output logic        tgt_req_o,
  output logic        tgt_we_o,
  output logic [7:0]  tgt_bus_o,
  output logic [7:0]  tgt_devfn_o,
  output logic [7:0]  tgt_off_o,
  output logic [3:0]  tgt_be_o,
  output logic [31:0] tgt_wdata_o,
  input  logic        tgt_present_i,
  input  logic        tgt_powered_i,
  input  logic        tgt_hotadd_i,
  input  logic        tgt_fn0_present_i,
  input  logic [31:0] tgt_rdata_i
);
  word_t      addr_q;
  logic [1:0] lane;
  logic       in_range;
  logic       target_ok;
  logic       pass;

  cfgh_addr_reg u_areg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (host_req_i && host_we_i && !host_data_i),
    .off_i    (host_off_i),
    .len_i    (host_len_i),
    .wdata_i  (host_wdata_i),
    .addr_q_o (addr_q)
  );

  cfgh_decode #(.CFG_LIMIT(CFG_LIMIT)) u_dec (
    .addr_lo_i  (addr_q[REG_OFF_W-1:0]),
    .off_i      (host_off_i),
    .len_i      (host_len_i),
    .reg_off_o  (tgt_off_o),
    .lane_o     (lane),
    .be_o       (tgt_be_o),
    .in_range_o (in_range)
  );

  // orphan hot-added function counts as absent
  assign target_ok = tgt_present_i && tgt_powered_i && !(tgt_hotadd_i && !tgt_fn0_present_i);
  assign pass      = addr_q[ENABLE_BIT] && target_ok && in_range;

  assign tgt_req_o   = host_req_i && host_data_i && pass;
  assign tgt_we_o    = host_we_i;
  assign tgt_bus_o   = addr_q[BUS_LSB +: BUS_W];
  assign tgt_devfn_o = addr_q[DEVFN_LSB +: DEVFN_W];
  assign tgt_wdata_o = host_wdata_i << {lane, 3'b000};

  cfgh_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (host_req_i && !host_we_i),
    .sel_data_i  (host_data_i),
    .pass_i      (pass),
    .addr_q_i    (addr_q),
    .lane_i      (lane),
    .be_i        (tgt_be_o),
    .tgt_rdata_i (tgt_rdata_i),
    .rdata_o     (host_rdata_o),
    .rvalid_o    (host_rvalid_o)
  );
endmodule

// File: rtl/cfgh_checker.sv
module cfgh_checker #(
  parameter int unsigned CFG_LIMIT = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_req_i,
  input logic        host_data_i,
  input logic        host_we_i,
  input logic [1:0]  host_off_i,
  input logic [2:0]  host_len_i,
  input logic [31:0] host_rdata_o,
  input logic        host_rvalid_o,
  input logic        tgt_req_o,
  input logic [7:0]  tgt_off_o,
  input logic [3:0]  tgt_be_o,
  input logic        tgt_present_i,
  input logic        tgt_powered_i,
  input logic        tgt_hotadd_i,
  input logic        tgt_fn0_present_i,
  input logic [31:0] addr_q
);
  p_addr_filter_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && host_we_i && !host_data_i && (host_off_i != 2'd0 || host_len_i != 3'd4)
    |=> $stable(addr_q));

  p_req_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> addr_q[31]);

  p_absent_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i && host_data_i && !tgt_present_i |=> host_rdata_o == 32'hFFFF_FFFF);

  p_req_needs_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> tgt_present_i && tgt_powered_i && !(tgt_hotadd_i && !tgt_fn0_present_i));

  p_req_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> (32'(tgt_off_o) < CFG_LIMIT) && (tgt_be_o != 4'h0));

  p_be_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> $countones(tgt_be_o) <= 32'(host_len_i));

  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i |=> host_rvalid_o);

  p_no_stray_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_req_i && !host_we_i) |=> !host_rvalid_o);
endmodule

bind cfgh_top cfgh_checker #(.CFG_LIMIT(CFG_LIMIT)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .host_req_i        (host_req_i),
  .host_data_i       (host_data_i),
  .host_we_i         (host_we_i),
  .host_off_i        (host_off_i),
  .host_len_i        (host_len_i),
  .host_rdata_o      (host_rdata_o),
  .host_rvalid_o     (host_rvalid_o),
  .tgt_req_o         (tgt_req_o),
  .tgt_off_o         (tgt_off_o),
  .tgt_be_o          (tgt_be_o),
  .tgt_present_i     (tgt_present_i),
  .tgt_powered_i     (tgt_powered_i),
  .tgt_hotadd_i      (tgt_hotadd_i),
  .tgt_fn0_present_i (tgt_fn0_present_i),
  .addr_q            (addr_q)
);

// File: tb/cfgh_top_tb.sv
module cfgh_top_tb;
  localparam int unsigned LIM = 158;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_data = 1'b0, host_we = 1'b0;
  logic [1:0]  host_off = '0;
  logic [2:0]  host_len = 3'd4;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        tgt_req, tgt_we;
  logic [7:0]  tgt_bus, tgt_devfn, tgt_off;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata, tgt_rdata;
  logic        pres = 1'b1, pwr = 1'b1, hp = 1'b0, f0 = 1'b1;

  int nvec = 0;
  int nerr = 0;
  logic [31:0] am = '0;  // bench mirror of the selector
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] tgt_word(logic [7:0] off, logic [7:0] devfn);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = ((off & 8'hFC) + 8'(i)) ^ devfn;
    return w;
  endfunction

  assign tgt_rdata = tgt_word(tgt_off, tgt_devfn);

  cfgh_top #(.CFG_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_data_i(host_data), .host_we_i(host_we),
    .host_off_i(host_off), .host_len_i(host_len), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .host_rvalid_o(host_rvalid),
    .tgt_req_o(tgt_req), .tgt_we_o(tgt_we), .tgt_bus_o(tgt_bus), .tgt_devfn_o(tgt_devfn),
    .tgt_off_o(tgt_off), .tgt_be_o(tgt_be), .tgt_wdata_o(tgt_wdata),
    .tgt_present_i(pres), .tgt_powered_i(pwr), .tgt_hotadd_i(hp),
    .tgt_fn0_present_i(f0), .tgt_rdata_i(tgt_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one host access with full expectation check
  task automatic acc(bit dsel, bit we, logic [1:0] off, logic [2:0] len, logic [31:0] wd,
                     bit p, bit w, bit h, bit f);
    logic [7:0]  eoff;
    logic [1:0]  lane;
    bit          inr, ok;
    int          n, keep;
    logic [3:0]  ebe;
    logic [31:0] erd, sh;
    @(negedge clk);
    host_req = 1; host_data = dsel; host_we = we; host_off = off; host_len = len; host_wdata = wd;
    pres = p; pwr = w; hp = h; f0 = f;
    #1;
    eoff = {am[7:2], am[1:0] | off};
    lane = eoff[1:0];
    inr  = 32'(eoff) < LIM;
    n    = inr ? ((int'(len) < int'(LIM) - int'(eoff)) ? int'(len) : int'(LIM) - int'(eoff)) : 0;
    for (int i = 0; i < 4; i++) ebe[i] = (i >= int'(lane)) && (i < int'(lane) + n);
    ok   = am[31] && p && w && !(h && !f) && inr;
    if (dsel) begin
      chk("R3/R6/R7/R8 tgt_req", 32'(tgt_req), 32'(ok));
      if (ok) begin
        chk("R4 bus", 32'(tgt_bus), 32'(am[23:16]));
        chk("R4 devfn", 32'(tgt_devfn), 32'(am[15:8]));
        chk("R5 offset", 32'(tgt_off), 32'(eoff));
        chk("R8/R9 byte enables", 32'(tgt_be), 32'(ebe));
        chk("R11 tgt_we", 32'(tgt_we), 32'(we));
        if (we) chk("R9 wdata lane", tgt_wdata, wd << (8 * int'(lane)));
      end
    end else begin
      chk("R11 no tgt_req on selector", 32'(tgt_req), 32'd0);
    end
    @(posedge clk); #1;
    host_req = 0;
    chk("R11 rvalid", 32'(host_rvalid), 32'(!we));
    if (!we) begin
      if (!dsel) erd = am;
      else if (!ok) erd = 32'hFFFF_FFFF;
      else begin
        sh = tgt_word(eoff, am[15:8]) >> (8 * int'(lane));
        keep = $countones(ebe);
        erd = '0;
        for (int k = 0; k < keep; k++) erd[8*k +: 8] = sh[8*k +: 8];
      end
      chk(dsel ? "R10/R6/R7/R3 rdata" : "R2 selector readback", host_rdata, erd);
    end
    if (!dsel && we && off == 2'd0 && len == 3'd4) am = wd;  // R1 model
  endtask

  function automatic logic [2:0] rnd_len();
    case ($urandom % 3) 0: return 3'd1; 1: return 3'd2; default: return 3'd4; endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset rvalid", 32'(host_rvalid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset no req", 32'(tgt_req), 32'd0);
    // R3: selector zero after reset, window disabled
    acc(0, 0, 2'd0, 3'd4, 0, 1, 1, 0, 1);
    acc(1, 0, 2'd0, 3'd4, 0, 1, 1, 0, 1);
    acc(1, 1, 2'd1, 3'd1, 32'h5A, 1, 1, 0, 1);
    // R1: narrow or offset selector writes ignored
    acc(0, 1, 2'd0, 3'd2, 32'h8000_1234, 1, 1, 0, 1);
    acc(0, 1, 2'd2, 3'd4, 32'h8000_1234, 1, 1, 0, 1);
    acc(0, 0, 2'd0, 3'd4, 0, 1, 1, 0, 1);
    acc(0, 1, 2'd0, 3'd4, 32'h8012_3440, 1, 1, 0, 1);
    // R2: readback at odd size
    acc(0, 0, 2'd3, 3'd1, 0, 1, 1, 0, 1);
    // R5/R9/R10: lanes and sizes
    acc(1, 0, 2'd2, 3'd2, 0, 1, 1, 0, 1);
    acc(1, 0, 2'd3, 3'd1, 0, 1, 1, 0, 1);
    acc(1, 0, 2'd1, 3'd4, 0, 1, 1, 0, 1);
    acc(1, 1, 2'd2, 3'd2, 32'h0000_BEEF, 1, 1, 0, 1);
    // R6, R7
    acc(1, 0, 2'd0, 3'd4, 0, 0, 1, 0, 1);
    acc(1, 1, 2'd0, 3'd4, 32'h1, 0, 1, 0, 1);
    acc(1, 0, 2'd0, 3'd4, 0, 1, 0, 0, 1);
    acc(1, 0, 2'd0, 3'd4, 0, 1, 1, 1, 0);
    acc(1, 1, 2'd0, 3'd4, 32'h2, 1, 1, 1, 0);
    acc(1, 0, 2'd0, 3'd4, 0, 1, 1, 1, 1);
    // R8: clipping near the limit, then beyond it
    acc(0, 1, 2'd0, 3'd4, 32'h8001_089C, 1, 1, 0, 1);
    acc(1, 0, 2'd0, 3'd4, 0, 1, 1, 0, 1);
    acc(1, 1, 2'd1, 3'd4, 32'hCAFE_F00D, 1, 1, 0, 1);
    acc(0, 1, 2'd0, 3'd4, 32'h8001_08A0, 1, 1, 0, 1);
    acc(1, 0, 2'd0, 3'd1, 0, 1, 1, 0, 1);
    acc(1, 1, 2'd0, 3'd1, 32'h3, 1, 1, 0, 1);
    acc(0, 1, 2'd0, 3'd4, 32'h8001_08FF, 1, 1, 0, 1);
    acc(1, 0, 2'd0, 3'd4, 0, 1, 1, 0, 1);
    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [31:0] v;
      bit dsel;
      v = $urandom;
      v[31] = ($urandom % 4) != 0;
      dsel = ($urandom % 4) != 0;
      acc(dsel, 1'($urandom), 2'($urandom),
          (dsel || ($urandom % 2)) ? rnd_len() : 3'd4, dsel ? $urandom : v,
          ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule